// File: doc/BRIEF.md
# Rectangle Blit Address Sequencer

This block produces the memory addresses for a rectangular copy or fill inside a linear frame buffer. Once it is started with a description of a source rectangle and a destination rectangle, it emits one pair of byte addresses per pixel, a source address and a destination address, on a valid/ready stream. A downstream data mover consumes the pairs at its own pace. The block does not touch pixel data, apply raster operations or clip.

Each axis can be walked forwards or backwards. When the command asks for a backwards walk on an axis, the walk begins on that axis's far edge and counts down. Software sets these bits so that a copy whose source and destination overlap within one surface never reads a pixel it has already overwritten. A destination-only mode serves solid or pattern fills: it produces destination addresses and leaves the source side idle.

All configuration is taken from packed words at the cycle `start` is accepted. After that, the block ignores its configuration inputs and any further `start` until the walk is over.

Top module: `blit_addr_walker`

## Requirements
- R1: After reset, `busy`, `addr_valid` and `src_active` are low, and both address outputs are zero.
- R2: The walk is row-major. A full row of width pixels is emitted before Y steps, and exactly width times height pairs are emitted. Width-1 is in `dims_word[11:0]` and height-1 is in `dims_word[27:16]`.
- R3: With `cmd_word[15]` clear, X runs from the programmed X upwards. With it set, X starts at X + width - 1 and decrements once per pixel, reloading at the start of every row.
- R4: With `cmd_word[14]` clear, Y runs from the programmed Y upwards. With it set, Y starts at Y + height - 1 and decrements once per row.
- R5: Each address is base*8 + y*pitch*8 + x*bytes_per_pixel, modulo 2^32. The start positions carry X in bits 11:0 and Y in bits 27:16. Bases are in 8-byte units. `pitch_word` holds the source pitch in bits 10:0 and the destination pitch in bits 26:16, both in 8-byte units.
- R6: The pixel depth comes from `mode_word[9:8]`: 00 means 1 byte per pixel, 01 means 2 and 11 means 4.
- R7: A `start` with depth code 10 is rejected. `busy` stays low and no pair is emitted.
- R8: While `addr_valid` is high and `addr_ready` is low, both addresses hold. The walk advances only on a cycle where valid and ready are both high.
- R9: `busy` and `addr_valid` go high in the cycle after an accepted `start`, stay high through the walk, and drop in the cycle after the last pair is accepted.
- R10: Configuration inputs are sampled only when `start` is accepted. `start` and input changes during a walk have no effect on the emitted pairs.
- R11: With `cmd_word[13]` set (destination-only), `src_active` stays low and `src_addr` stays zero, while destination addresses follow R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request; taken only while idle |
| cmd_word | input | 32 | Bit 15 reverse X, bit 14 reverse Y, bit 13 destination-only |
| mode_word | input | 32 | Bits 9:8 depth code |
| dims_word | input | 32 | Width-1 in bits 11:0, height-1 in bits 27:16 |
| src_pos_word | input | 32 | Source X in bits 11:0, Y in bits 27:16 |
| dst_pos_word | input | 32 | Destination X in bits 11:0, Y in bits 27:16 |
| pitch_word | input | 32 | Source pitch in bits 10:0, destination pitch in bits 26:16, in 8-byte units |
| src_base | input | BASE_W | Source base address in 8-byte units |
| dst_base | input | BASE_W | Destination base address in 8-byte units |
| busy | output | 1 | Walk in progress |
| addr_valid | output | 1 | An address pair is presented |
| addr_ready | input | 1 | Consumer takes the presented pair |
| src_active | output | 1 | The source address is meaningful for this pair |
| src_addr | output | ADDR_W | Source byte address |
| dst_addr | output | ADDR_W | Destination byte address |

## Verification
The bench targets the corners of each axis. These are a reversed walk whose far edge lands on coordinate 4095, single-pixel and single-row rectangles, and rows long enough that an off-by-one in the row reload would skew every later row. A design that placed the reverse start at X + width instead of X + width - 1, or stepped Y before a row was complete, would produce a wrong address on the first or on a row-boundary beat. Random backpressure tests the hold behaviour: a design that advanced on valid alone would skip addresses. Configuration words are also scrambled and `start` is re-pulsed mid-walk, which catches a design that samples inputs continuously. The reserved depth code and the destination-only mode are checked at the outputs, where a wrong design would go busy or drive a source address.

// File: rtl/blit_walk_pkg.sv
package blit_walk_pkg;

    // Field positions inside the packed configuration words
    localparam int CMD_XREV_BIT    = 15;
    localparam int CMD_YREV_BIT    = 14;
    localparam int CMD_DSTONLY_BIT = 13;
    localparam int DEPTH_LSB       = 8;
    localparam int HI_FIELD_LSB    = 16;

    typedef enum logic [1:0] {
        DEPTH_8   = 2'b00,
        DEPTH_16  = 2'b01,
        DEPTH_RSV = 2'b10,
        DEPTH_32  = 2'b11
    } depth_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic x_rev;
        logic y_rev;
        logic dst_only;
    } walk_flags_t;

    function automatic logic depth_ok(input depth_code_e code);
        return code != DEPTH_RSV;
    endfunction

    // log2 of bytes per pixel
    function automatic logic [1:0] depth_shift(input depth_code_e code);
        case (code)
            DEPTH_16: return 2'd1;
            DEPTH_32: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic walk_flags_t decode_flags(input logic [31:0] cmd);
        walk_flags_t f;
        f.x_rev    = cmd[CMD_XREV_BIT];
        f.y_rev    = cmd[CMD_YREV_BIT];
        f.dst_only = cmd[CMD_DSTONLY_BIT];
        return f;
    endfunction

endpackage

// File: rtl/blit_axis_walk.sv
module blit_axis_walk #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          rev,
    input  logic [CW-1:0] origin,
    input  logic [CW-1:0] span_m1,
    output logic [CW:0]   coord,
    output logic          at_end
);

    logic [CW:0]   coord_q;
    logic [CW:0]   first_q;
    logic [CW-1:0] rem_q;
    logic [CW-1:0] span_q;
    logic          rev_q;
    logic [CW:0]   first_d;

    // Backwards walks begin on the far edge of the span
    always_comb begin
        if (rev)
            first_d = {1'b0, origin} + {1'b0, span_m1};
        else
            first_d = {1'b0, origin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coord_q <= '0;
            first_q <= '0;
            rem_q   <= '0;
            span_q  <= '0;
            rev_q   <= 1'b0;
        end else if (load) begin
            coord_q <= first_d;
            first_q <= first_d;
            rem_q   <= span_m1;
            span_q  <= span_m1;
            rev_q   <= rev;
        end else if (step) begin
            if (rem_q == '0) begin
                coord_q <= first_q;
                rem_q   <= span_q;
            end else begin
                coord_q <= rev_q ? coord_q - (CW+1)'(1) : coord_q + (CW+1)'(1);
                rem_q   <= rem_q - CW'(1);
            end
        end
    end

    assign coord  = coord_q;
    assign at_end = (rem_q == '0);

    // R3 on the X instances, R4 on the Y instances
    assert_step_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !at_end && !rev_q) |=> (coord == $past(coord) + (CW+1)'(1)));

    assert_step_rev_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !at_end && rev_q) |=> (coord == $past(coord) - (CW+1)'(1)));

    assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !load && at_end) |=> (rem_q == $past(span_q)));

    always_comb begin
        if (!rst) assert_rem_bound_R2: assert (rem_q <= span_q);
    end

endmodule

// File: rtl/blit_addr_map.sv
module blit_addr_map #(
    parameter int CW = 12,
    parameter int PW = 11,
    parameter int BW = 29,
    parameter int AW = 32
) (
    input  logic [BW-1:0] base,
    input  logic [PW-1:0] pitch,
    input  logic [CW:0]   x,
    input  logic [CW:0]   y,
    input  logic [1:0]    shift,
    output logic [AW-1:0] addr
);

    localparam int UNIT_LOG2 = 3;

    logic [AW-1:0] base_bytes;
    logic [AW-1:0] row_bytes;
    logic [AW-1:0] col_bytes;

    always_comb begin
        base_bytes = AW'(base) << UNIT_LOG2;
        row_bytes  = AW'(y) * (AW'(pitch) << UNIT_LOG2);
        col_bytes  = AW'(x) << shift;
        addr       = base_bytes + row_bytes + col_bytes;
    end

endmodule

// File: rtl/blit_addr_walker.sv
module blit_addr_walker
    import blit_walk_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int PITCH_W = 11,
    parameter int BASE_W  = 29,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       cmd_word,
    input  logic [31:0]       mode_word,
    input  logic [31:0]       dims_word,
    input  logic [31:0]       src_pos_word,
    input  logic [31:0]       dst_pos_word,
    input  logic [31:0]       pitch_word,
    input  logic [BASE_W-1:0] src_base,
    input  logic [BASE_W-1:0] dst_base,
    output logic              busy,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic              src_active,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int NSURF = 2;   // index 0 source, 1 destination
    localparam int SRC   = 0;
    localparam int DST   = 1;

    walk_state_e   state_q;
    walk_flags_t   flags_q;
    walk_flags_t   flags_in;
    depth_code_e   code_in;
    logic [1:0]    shift_q;
    logic          launch;
    logic          accept;
    logic          last_beat;

    logic [COORD_W-1:0] width_m1;
    logic [COORD_W-1:0] height_m1;
    logic [COORD_W-1:0] org_x   [NSURF];
    logic [COORD_W-1:0] org_y   [NSURF];
    logic [BASE_W-1:0]  base_in [NSURF];
    logic [PITCH_W-1:0] pitch_in[NSURF];
    logic [BASE_W-1:0]  base_q  [NSURF];
    logic [PITCH_W-1:0] pitch_q [NSURF];
    logic [COORD_W:0]   x_c     [NSURF];
    logic [COORD_W:0]   y_c     [NSURF];
    logic               x_end   [NSURF];
    logic               y_end   [NSURF];
    logic [ADDR_W-1:0]  addr_raw[NSURF];

    logic unused_cfg;
    assign unused_cfg = ^{cmd_word, mode_word, dims_word, src_pos_word,
                          dst_pos_word, pitch_word};

    // Field decode
    assign flags_in   = decode_flags(cmd_word);
    assign code_in    = depth_code_e'(mode_word[DEPTH_LSB +: 2]);
    assign width_m1   = dims_word[COORD_W-1:0];
    assign height_m1  = dims_word[HI_FIELD_LSB +: COORD_W];
    assign org_x[SRC] = src_pos_word[COORD_W-1:0];
    assign org_y[SRC] = src_pos_word[HI_FIELD_LSB +: COORD_W];
    assign org_x[DST] = dst_pos_word[COORD_W-1:0];
    assign org_y[DST] = dst_pos_word[HI_FIELD_LSB +: COORD_W];
    assign base_in[SRC]  = src_base;
    assign base_in[DST]  = dst_base;
    assign pitch_in[SRC] = pitch_word[PITCH_W-1:0];
    assign pitch_in[DST] = pitch_word[HI_FIELD_LSB +: PITCH_W];

    assign launch    = (state_q == ST_IDLE) && start && depth_ok(code_in);
    assign accept    = (state_q == ST_RUN) && addr_ready;
    assign last_beat = x_end[DST] && y_end[DST];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            shift_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch) begin
                    state_q <= ST_RUN;
                    flags_q <= flags_in;
                    shift_q <= depth_shift(code_in);
                end
                ST_RUN: if (accept && last_beat) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One pair of axis walkers and one address map per surface
    for (genvar s = 0; s < NSURF; s++) begin : g_surf
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[s]  <= '0;
                pitch_q[s] <= '0;
            end else if (launch) begin
                base_q[s]  <= base_in[s];
                pitch_q[s] <= pitch_in[s];
            end
        end

        blit_axis_walk #(.CW(COORD_W)) u_x (
            .clk    (clk),
            .rst    (rst),
            .load   (launch),
            .step   (accept),
            .rev    (flags_in.x_rev),
            .origin (org_x[s]),
            .span_m1(width_m1),
            .coord  (x_c[s]),
            .at_end (x_end[s])
        );

        blit_axis_walk #(.CW(COORD_W)) u_y (
            .clk    (clk),
            .rst    (rst),
            .load   (launch),
            .step   (accept && x_end[s]),
            .rev    (flags_in.y_rev),
            .origin (org_y[s]),
            .span_m1(height_m1),
            .coord  (y_c[s]),
            .at_end (y_end[s])
        );

        blit_addr_map #(
            .CW(COORD_W), .PW(PITCH_W), .BW(BASE_W), .AW(ADDR_W)
        ) u_map (
            .base (base_q[s]),
            .pitch(pitch_q[s]),
            .x    (x_c[s]),
            .y    (y_c[s]),
            .shift(shift_q),
            .addr (addr_raw[s])
        );
    end

    assign busy       = (state_q == ST_RUN);
    assign addr_valid = busy;
    assign src_active = busy && !flags_q.dst_only;
    assign src_addr   = src_active ? addr_raw[SRC] : '0;
    assign dst_addr   = busy ? addr_raw[DST] : '0;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=>
            (addr_valid && $stable(dst_addr) && $stable(src_addr)));

    assert_reject_rsv_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (mode_word[DEPTH_LSB +: 2] == 2'b10)) |=> !busy);

    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(addr_valid && addr_ready));

    assert_row_first_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !x_end[DST]) |=> $stable(y_c[DST]));

    assert_lockstep_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (x_end[SRC] == x_end[DST]) && (y_end[SRC] == y_end[DST]));

endmodule

// File: tb/blit_addr_walker_bench.sv
module blit_addr_walker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] cmd_word, mode_word, dims_word, src_pos_word, dst_pos_word, pitch_word;
    logic [28:0] src_base, dst_base;
    logic        busy, addr_valid, addr_ready, src_active;
    logic [31:0] src_addr, dst_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;   // 50 MHz

    blit_addr_walker u_blit_addr_walker (
        .clk(clk), .rst(rst), .start(start),
        .cmd_word(cmd_word), .mode_word(mode_word), .dims_word(dims_word),
        .src_pos_word(src_pos_word), .dst_pos_word(dst_pos_word),
        .pitch_word(pitch_word), .src_base(src_base), .dst_base(dst_base),
        .busy(busy), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .src_active(src_active), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R9 actual=%0d expected=<150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_addr(input logic [28:0] base, input logic [10:0] pitch,
                                             input int x, input int y, input int bpp);
        return ({3'b0, base} << 3) + 32'(y) * (32'(pitch) * 32'd8) + 32'(x) * 32'(bpp);
    endfunction

    function automatic int axis_pos(input int org, input int span, input int idx, input bit rev);
        return rev ? org + span - 1 - idx : org + idx;
    endfunction

    task automatic scramble();
        cmd_word     = $urandom;
        mode_word    = $urandom;
        dims_word    = $urandom;
        src_pos_word = $urandom;
        dst_pos_word = $urandom;
        pitch_word   = $urandom;
        src_base     = 29'($urandom);
        dst_base     = 29'($urandom);
    endtask

    task automatic run_job(input string tag, input int sx, input int sy, input int dx,
                           input int dy, input int w, input int h, input bit xr,
                           input bit yr, input bit fill, input logic [1:0] code,
                           input logic [28:0] sb, input logic [28:0] db,
                           input logic [10:0] sp, input logic [10:0] dp,
                           input int ready_pct, input bit poke);
        int bpp = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
        int total = w * h;
        int k = 0;
        @(negedge clk);
        cmd_word     = {16'h0, xr, yr, fill, 13'h0};
        mode_word    = {22'h0, code, 8'h0};
        dims_word    = {4'h0, 12'(h - 1), 4'h0, 12'(w - 1)};
        src_pos_word = {4'h0, 12'(sy), 4'h0, 12'(sx)};
        dst_pos_word = {4'h0, 12'(dy), 4'h0, 12'(dx)};
        pitch_word   = {5'h0, dp, 5'h0, sp};
        src_base     = sb;
        dst_base     = db;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && addr_valid === 1'b1, {tag, " R9 busy after start"},
              {30'h0, busy, addr_valid}, 32'h3);
        while (k < total) begin
            int c = k % w;
            int r = k / w;
            logic [31:0] exp_d = ref_addr(db, dp, axis_pos(dx, w, c, xr), axis_pos(dy, h, r, yr), bpp);
            logic [31:0] exp_s = fill ? 32'h0 :
                ref_addr(sb, sp, axis_pos(sx, w, c, xr), axis_pos(sy, h, r, yr), bpp);
            bit rdy = ($urandom_range(99) < ready_pct);
            check(addr_valid === 1'b1, {tag, " R9 valid in walk"}, {31'h0, addr_valid}, 32'h1);
            check(dst_addr === exp_d, {tag, " R2 R3 R4 R5 R6 R8 dst"}, dst_addr, exp_d);
            if (fill)
                check(src_active === 1'b0 && src_addr === 32'h0, {tag, " R11 src idle"},
                      src_addr, 32'h0);
            else
                check(src_active === 1'b1 && src_addr === exp_s, {tag, " R2 R5 R8 src"},
                      src_addr, exp_s);
            addr_ready = rdy;
            if (poke) begin
                scramble();
                start = (k + 1 < total) ? 1'($urandom_range(1)) : 1'b0;
            end
            if (rdy) k++;
            @(negedge clk);
        end
        addr_ready = 1'b0;
        start      = 1'b0;
        check(busy === 1'b0 && addr_valid === 1'b0, {tag, " R9 busy drops after last"},
              {30'h0, busy, addr_valid}, 32'h0);
        @(negedge clk);
        check(busy === 1'b0, {tag, " R2 R10 no extra walk"}, {31'h0, busy}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; addr_ready = 1'b0;
        cmd_word = '0; mode_word = '0; dims_word = '0; src_pos_word = '0;
        dst_pos_word = '0; pitch_word = '0; src_base = '0; dst_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && addr_valid === 1'b0 && src_active === 1'b0,
              "R1 reset flags", {29'h0, busy, addr_valid, src_active}, 32'h0);
        check(src_addr === 32'h0 && dst_addr === 32'h0, "R1 reset addr",
              src_addr | dst_addr, 32'h0);

        // Directed corners
        run_job("fwd8",    3, 5, 10, 2, 4, 3, 0, 0, 0, 2'b00, 29'h100, 29'h2000, 11'd40, 11'd80, 100, 0);
        run_job("xrev16",  7, 1,  9, 1, 3, 2, 1, 0, 0, 2'b01, 29'h0,   29'h0,    11'd64, 11'd64, 60, 0);
        run_job("yrev32",  0, 0,  0, 2, 2, 4, 0, 1, 0, 2'b11, 29'h40,  29'h40,   11'd16, 11'd16, 70, 0);
        run_job("bothrev", 4, 4,  6, 7, 5, 3, 1, 1, 0, 2'b01, 29'h8,   29'h8,    11'd128, 11'd128, 50, 0);
        run_job("fill",    0, 0, 20, 9, 6, 2, 0, 0, 1, 2'b11, 29'h77,  29'h1000, 11'd5, 11'd300, 80, 0);
        run_job("one",     1, 1,  2, 2, 1, 1, 1, 1, 0, 2'b00, 29'h1,   29'h2,    11'd1, 11'd2, 100, 0);
        run_job("edgex",   4095, 4095, 4095, 4095, 1, 1, 1, 1, 0, 2'b11, 29'h1FFFFFFF, 29'h0, 11'd2047, 11'd2047, 100, 0);
        run_job("farrev",  4000, 10, 4000, 11, 96, 2, 1, 0, 0, 2'b00, 29'h0, 29'h10, 11'd600, 11'd600, 90, 0);
        run_job("wide",    0, 0, 1, 0, 200, 2, 0, 0, 0, 2'b01, 29'h3, 29'h5, 11'd100, 11'd100, 100, 0);
        run_job("poke R10", 2, 3, 4, 5, 5, 4, 1, 0, 0, 2'b11, 29'h9, 29'hA, 11'd50, 11'd60, 50, 1);

        // Reserved depth code is refused
        @(negedge clk);
        cmd_word = '0; mode_word = 32'h0000_0200; dims_word = 32'h0003_0003;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0 && addr_valid === 1'b0, "R7 reserved depth refused",
              {30'h0, busy, addr_valid}, 32'h0);
        @(negedge clk);
        check(busy === 1'b0 && dst_addr === 32'h0, "R7 still idle", dst_addr, 32'h0);
        run_job("afterrej", 1, 2, 3, 4, 2, 2, 0, 0, 0, 2'b00, 29'h4, 29'h6, 11'd8, 11'd8, 100, 0);

        // Random jobs
        for (int j = 0; j < 40; j++) begin
            int w  = 1 + $urandom_range(15);
            int h  = 1 + $urandom_range(7);
            int cs = $urandom_range(2);
            logic [1:0] code = (cs == 0) ? 2'b00 : (cs == 1) ? 2'b01 : 2'b11;
            run_job("rand R6", $urandom_range(4095), $urandom_range(4095),
                    $urandom_range(4095), $urandom_range(4095), w, h,
                    1'($urandom_range(1)), 1'($urandom_range(1)), ($urandom_range(3) == 0),
                    code, 29'($urandom), 29'($urandom), 11'($urandom), 11'($urandom),
                    30 + $urandom_range(70), ($urandom_range(4) == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule